// File: doc/BRIEF.md
# Periodic Wake-Up Timer with Prescaler and Auto-Reload

This block is a low-power periodic wake timer. A fixed-width prescaler divides the selected count clock. Each prescaler wrap steps a loadable down counter. The counter path is 23 bits by default: 7 prescaler bits and 16 counter bits. When the counter is at zero and the prescaler wraps again, the counter takes back its programmed reload value and raises a sticky expiry flag. That flag, gated by its enable, drives an interrupt / wake-up request. The request can leave a powered-down system, so the timer keeps counting whatever the rest of the device is doing.

Software programs the block through a small synchronous register port and reads it back through the same port. The count source is either the CPU clock or a synchronised crystal tick enable. When the CPU itself already runs from the crystal, the CPU clock path is forced. The block sits in the power-on reset domain only: its `por_rst` input is meant to be driven by power-on reset alone, so warm resets of the rest of the chip leave it running.

Top module: `wake_timer`

## Requirements
- R1: After power-on reset the reload register and the counter read all ones, the control register (address 1) reads 0, and `wake_req` is 0.
- R2: Register map: address 0 is the reload value, address 1 is control, address 2 reads the live count. Control bits: bit 0 enable, bit 1 crystal source, bit 2 expiry flag, bit 3 request enable. After enable is written to 1, the first expiry occurs (R+1)·2^PRE_W count ticks later, where R is the reload value.
- R3: At an expiry the counter reloads from the reload register, so later expiries repeat every (R+1)·2^PRE_W ticks.
- R4: Writing the reload register while the timer is disabled also presets the counter to the written value. The prescaler is held cleared while the timer is disabled.
- R5: While the timer is disabled, the counter does not change except through a preset write.
- R6: With control bit 1 at 0, every clock is a count tick. With bit 1 at 1 and `cpu_is_xtal` low, only cycles with `xtal_tick` high are ticks. With bit 1 at 1 and `cpu_is_xtal` high, every clock is a tick.
- R7: The expiry flag stays set until a control write with bit 2 at 0. A control write with bit 2 at 1 neither sets nor clears it.
- R8: If an expiry and a flag-clearing control write fall on the same clock edge, the flag ends up set.
- R9: `wake_req` is high exactly when the expiry flag and the request enable (control bit 3) are both set. It changes on the same edge as either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (CPU clock domain) |
| por_rst | input | 1 | Synchronous active-high power-on reset |
| cpu_is_xtal | input | 1 | CPU clock is currently the crystal clock |
| xtal_tick | input | 1 | Synchronised one-cycle crystal tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Registered read data |
| wake_req | output | 1 | Registered interrupt / wake-up request |

## Verification
Two things can land on the same edge: the counter expiring, which sets the flag, and software writing control with the flag bit at 0, which clears it. The bench counts edges from the enable write and issues the clearing write so that it lands exactly on the computed expiry edge. It then requires the request to remain high, and requires a later clearing write to drop it. Expiry timing is swept over every reload value of a reduced configuration. Each measured interval is compared against (R+1)·2^PRE_W.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    WT_REG_RELOAD = 2'd0,
    WT_REG_CTRL   = 2'd1,
    WT_REG_COUNT  = 2'd2
  } wt_reg_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_XSRC = 1;
  localparam int CTL_FLAG = 2;
  localparam int CTL_IE   = 3;
  localparam int CTL_W    = 4;
endpackage

// File: rtl/wt_tick_sel.sv
module wt_tick_sel (
  input  logic src_xtal,
  input  logic cpu_is_xtal,
  input  logic xtal_tick,
  output logic tick
);
  logic use_xtal;
  always_comb begin
    use_xtal = src_xtal & ~cpu_is_xtal;
    tick     = use_xtal ? xtal_tick : 1'b1;
  end
endmodule

// File: rtl/wt_prescaler.sv
module wt_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic carry
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
  logic [PRE_W-1:0] pre_q;

  assign carry = run & tick & (pre_q == PRE_MAX);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (tick)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wt_downcount.sv
module wt_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             preset,
  input  logic [CNT_W-1:0] preset_val,
  input  logic             step,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign expire = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '1;
    else if (preset) cnt_q <= preset_val;
    else if (expire) cnt_q <= reload_val;
    else if (step)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int PRE_W = 7,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             cpu_is_xtal,
  input  logic             xtal_tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             wake_req
);
  import wt_pkg::*;

  localparam int PAD_W = CNT_W - CTL_W;

  logic [CNT_W-1:0] reload_q;
  logic             en_q, src_q, flag_q, ie_q;
  logic             flag_d, ie_d;
  logic             wr_reload, wr_ctrl, preset;
  logic             tick, pre_carry, expire;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] rd_data_q;
  logic             wake_q;
  logic [CTL_W-1:0] ctrl_view;

  assign wr_reload = wr_en && (wr_addr == WT_REG_RELOAD);
  assign wr_ctrl   = wr_en && (wr_addr == WT_REG_CTRL);
  assign preset    = wr_reload && !en_q;

  wt_tick_sel u_sel (
    .src_xtal    (src_q),
    .cpu_is_xtal (cpu_is_xtal),
    .xtal_tick   (xtal_tick),
    .tick        (tick)
  );

  wt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst   (por_rst),
    .run   (en_q),
    .tick  (tick),
    .carry (pre_carry)
  );

  wt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (por_rst),
    .preset     (preset),
    .preset_val (wr_data),
    .step       (pre_carry),
    .reload_val (reload_q),
    .cnt        (cnt_val),
    .expire     (expire)
  );

  // Expiry outranks a software clear on the same edge.
  always_comb begin
    flag_d = flag_q;
    if (wr_ctrl && !wr_data[CTL_FLAG]) flag_d = 1'b0;
    if (expire)                        flag_d = 1'b1;
    ie_d = wr_ctrl ? wr_data[CTL_IE] : ie_q;
  end

  always_ff @(posedge clk) begin
    if (por_rst) begin
      reload_q <= '1;
      en_q     <= 1'b0;
      src_q    <= 1'b0;
      flag_q   <= 1'b0;
      ie_q     <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wr_data;
      if (wr_ctrl) begin
        en_q  <= wr_data[CTL_EN];
        src_q <= wr_data[CTL_XSRC];
      end
      flag_q <= flag_d;
      ie_q   <= ie_d;
      wake_q <= flag_d & ie_d;
    end
  end

  always_comb begin
    ctrl_view           = '0;
    ctrl_view[CTL_EN]   = en_q;
    ctrl_view[CTL_XSRC] = src_q;
    ctrl_view[CTL_FLAG] = flag_q;
    ctrl_view[CTL_IE]   = ie_q;
  end

  always_ff @(posedge clk) begin
    if (por_rst) rd_data_q <= '0;
    else begin
      case (rd_addr)
        WT_REG_RELOAD: rd_data_q <= reload_q;
        WT_REG_CTRL:   rd_data_q <= {{PAD_W{1'b0}}, ctrl_view};
        WT_REG_COUNT:  rd_data_q <= cnt_val;
        default:       rd_data_q <= '0;
      endcase
    end
  end

  assign rd_data  = rd_data_q;
  assign wake_req = wake_q;
endmodule

// File: rtl/wake_timer_chk.sv
module wake_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             por_rst,
  input logic             cpu_is_xtal,
  input logic             xtal_tick,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             wake_req,
  input logic             en_q,
  input logic             src_q,
  input logic             flag_q,
  input logic             pre_carry,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] reload_q
);
  import wt_pkg::*;

  logic wr_rl, wr_ct;
  assign wr_rl = wr_en && (wr_addr == WT_REG_RELOAD);
  assign wr_ct = wr_en && (wr_addr == WT_REG_CTRL);

  AST_RST_QUIET: assert property (@(posedge clk) por_rst |=> (!wake_req && !en_q && !flag_q)); // R1

  AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (por_rst)
    (pre_carry && cnt_val == '0 && !wr_rl) |=> (cnt_val == $past(reload_q))); // R3

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (por_rst)
    (!en_q && !wr_rl) |=> $stable(cnt_val)); // R5

  AST_NO_XTAL_TICK: assert property (@(posedge clk) disable iff (por_rst)
    (en_q && src_q && !cpu_is_xtal && !xtal_tick) |=> $stable(cnt_val)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por_rst)
    (flag_q && !wr_ct) |=> flag_q); // R7

  AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (por_rst)
    (pre_carry && cnt_val == '0) |=> flag_q); // R8

  AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (por_rst)
    wake_req |-> flag_q); // R9
endmodule

bind wake_timer wake_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .por_rst     (por_rst),
  .cpu_is_xtal (cpu_is_xtal),
  .xtal_tick   (xtal_tick),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wake_req    (wake_req),
  .en_q        (en_q),
  .src_q       (src_q),
  .flag_q      (flag_q),
  .pre_carry   (pre_carry),
  .cnt_val     (cnt_val),
  .reload_q    (reload_q)
);

// File: tb/wake_timer_tb_top.sv
module wake_timer_tb_top;
  localparam int PRE_W = 2;
  localparam int CNT_W = 4;
  localparam int PSC   = 1 << PRE_W;

  logic             clk = 1'b0;
  logic             por_rst = 1'b1;
  logic             cpu_is_xtal = 1'b0;
  logic             xtal_tick = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic [1:0]       rd_addr = '0;
  logic [CNT_W-1:0] rd_data;
  logic             wake_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wake_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .por_rst(por_rst), .cpu_is_xtal(cpu_is_xtal), .xtal_tick(xtal_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wake_req(wake_req)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic measure(input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (wake_req) begin n = k; break; end
    end
  endtask

  initial begin
    #3_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int v, n, v2;
    repeat (3) @(posedge clk);
    @(negedge clk); por_rst = 1'b0;

    rd(2'd0, v); chk("R1 reload", v, 15);
    rd(2'd1, v); chk("R1 ctrl", v, 0);
    rd(2'd2, v); chk("R1 count", v, 15);
    chk("R1 wake", int'(wake_req), 0);

    // Sweep every reload value: preset, first period, repeat period
    for (int r = 0; r < 16; r++) begin
      wr(2'd1, 0);
      wr(2'd0, r);
      rd(2'd2, v); chk("R4 preset", v, r);
      wr(2'd1, 9);
      measure(200, n); chk("R2 first expiry", n, (r + 1) * PSC);
      wr(2'd1, 9);
      measure(200, n); chk("R3 repeat expiry", n, (r + 1) * PSC - 2);
    end

    // Disabled: frozen count
    wr(2'd1, 0);
    rd(2'd2, v);
    repeat (20) @(posedge clk);
    rd(2'd2, v2); chk("R5 frozen", v2, v);
    chk("R5 no wake", int'(wake_req), 0);

    // Writing flag bit 1 does not set it
    wr(2'd1, 12);
    chk("R7 write1 no set", int'(wake_req), 0);
    rd(2'd1, v); chk("R7 flag clear", (v >> 2) & 1, 0);

    // Expiry and clear on the same edge
    wr(2'd1, 0);
    wr(2'd0, 3);
    wr(2'd1, 9);
    repeat (4 * PSC - 1) @(posedge clk);
    wr(2'd1, 9);
    chk("R8 set wins", int'(wake_req), 1);
    wr(2'd1, 9);
    chk("R7 clear", int'(wake_req), 0);

    // Request masking
    wr(2'd1, 0);
    wr(2'd0, 0);
    wr(2'd1, 1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R9 masked", int'(wake_req), 0);
    rd(2'd1, v); chk("R7 flag set", (v >> 2) & 1, 1);
    wr(2'd1, 13);
    chk("R9 unmasked", int'(wake_req), 1);
    wr(2'd1, 5);
    chk("R9 remask", int'(wake_req), 0);

    // Crystal source with no ticks
    wr(2'd1, 0);
    wr(2'd0, 2);
    wr(2'd1, 11);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R6 no tick wake", int'(wake_req), 0);
    rd(2'd2, v); chk("R6 no tick count", v, 2);
    cpu_is_xtal = 1'b1;
    measure(200, n); chk("R6 forced cpu clock", n, 3 * PSC);

    // Crystal ticks every third cycle
    cpu_is_xtal = 1'b0;
    wr(2'd1, 0);
    wr(2'd0, 1);
    wr(2'd1, 11);
    n = -1;
    for (int k = 0; k < 200; k++) begin
      xtal_tick = (k % 3 == 0);
      @(posedge clk);
      @(negedge clk);
      if (wake_req) begin n = k + 1; break; end
    end
    xtal_tick = 1'b0;
    chk("R6 xtal ticks", n, 3 * (2 * PSC - 1) + 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule